// File: doc/BRIEF.md
# Secondary Interrupt Handler Bank

This block gathers up to 24 event inputs and reports them to two hosts, each on its own active-low interrupt line. Every source passes through a two-flop synchroniser and an edge detector. A two-bit field per source chooses rising, falling, either or no edge. A detected event latches into a status bit on both lines at once. Each line has its own status register and its own mask register, so the two hosts can service and acknowledge events without disturbing each other. The edge-select register is shared by both lines.

Software reaches the bank over a simple synchronous byte-wide register bus with one write strobe and one read strobe. Data is captured or returned in the cycle of the strobe, with no back-pressure. A read strobe loads `reg_rdata` at the next clock edge, and the value then holds until the next read. A control bit chooses how status is acknowledged. With clear-on-read set, a read of a status byte clears that byte. Otherwise a status bit is cleared by writing a 1 to it. A test register sets status bits on both lines without any source activity. If an event arrives while its status bit is already set, it is held as one extra pending event, and the status bit comes back after it is cleared.

Register map with the defaults, little-endian, source k at bit k%8 of byte k/8:

| Bytes | Register |
|---|---|
| 0-2 | line 0 status |
| 3-5 | line 0 mask |
| 6-8 | line 1 status |
| 9-11 | line 1 mask |
| 12-17 | edge select |
| 18 | control, bit 0 selects clear-on-read |
| 19-21 | status set for test, write only, reads 0 |

Top module: `sih_bank`

## Requirements
- R1: After reset both `irq_n` bits are 1, all status bits read 0, all mask bytes read 8'hFF, the edge-select bytes read 0 and the control byte reads 0.
- R2: A source whose edge field has its upper bit set latches a status bit on both lines after a 0-to-1 input change. The bit is visible three clock edges after the input changes.
- R3: The lower bit of the field enables the 1-to-0 edge, and with both bits set either edge latches. An edge of a kind that is not enabled latches nothing.
- R4: A source whose edge field is 2'b00 never latches a status bit, whatever its input does.
- R5: `irq_n[l]` is 0 exactly when some status bit of line l has a 0 in the same bit of line l's mask. The two lines are independent, and a mask of all ones keeps the line at 1.
- R6: With the control bit at 0, writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A read does not clear status in this mode.
- R7: With the control bit at 1, reading a status byte returns its bits and clears them. Writes to status bytes are ignored in this mode.
- R8: An event on a source whose status bit is already set is held as one pending event. After the status bit is cleared it reads 1 again, and a second clear leaves it at 0. Further repeat events do not add more than one pending event.
- R9: Writing a byte to the status-set register ORs that byte into the matching status byte of both lines.
- R10: Source i's edge field is at bits (i%4)*2+1 (rising) and (i%4)*2 (falling) of edge byte i/4. Status and mask bytes place source i at bit i%8 of byte i/8, with byte 0 at the lowest address of each register.
- R11: `reg_rdata` changes only on the clock edge that samples `reg_rd`, and it shows the addressed byte as it stood before that edge.
- R12: An event that arrives in the same cycle as a clear of its status bit is not lost, and the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Asynchronous event inputs |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_rd | input | 1 | Read strobe, one cycle per byte |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 2 | Active-low interrupt outputs, one per host |

## Verification
The hardest case to reach is a source edge that lands in exactly the cycle when software clears that same status bit. The bench drives the input on a falling clock edge. It then counts two rising edges through the synchroniser and raises the write-one-to-clear strobe so that it is sampled on the third edge, where the detector fires. The pending-event path also needs a second event on a bit that is already set, which is hard to time from the source pins. The bench produces it by writing the status-set register twice or three times before it clears.

// File: rtl/sih_pkg.sv
package sih_pkg;
  typedef enum logic [2:0] {
    RG_STAT0, RG_MASK0, RG_STAT1, RG_MASK1, RG_EDGE, RG_CTRL, RG_TSET, RG_NONE
  } sih_region_e;

  localparam int unsigned CTRL_COR_BIT = 0;
  localparam int unsigned N_LINES      = 2;
endpackage

// File: rtl/sih_src_detect.sv
module sih_src_detect #(
  parameter int unsigned N_SRC = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_i,
  input  logic [2*N_SRC-1:0] edge_cfg,
  output logic [N_SRC-1:0]   evt_o
);
  logic [N_SRC-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // upper bit of each field arms the rising edge, lower bit the falling edge
  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
    logic rise, fall;
    assign rise = sync_q[gi] & ~prev_q[gi];
    assign fall = ~sync_q[gi] & prev_q[gi];
    assign evt_o[gi] = (edge_cfg[2*gi+1] & rise) | (edge_cfg[2*gi] & fall);
  end
endmodule

// File: rtl/sih_line_bank.sv
module sih_line_bank #(
  parameter int unsigned N_SRC = 24,
  parameter int unsigned SB    = (N_SRC + 7) / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic [N_SRC-1:0]  clr_i,
  input  logic [SB-1:0]     mask_we_i,
  input  logic [7:0]        mask_wdata_i,
  output logic [N_SRC-1:0]  stat_o,
  output logic [N_SRC-1:0]  pend_o,
  output logic [SB*8-1:0]   mask_o,
  output logic              irq_n_o
);
  logic [N_SRC-1:0] stat_q, pend_q, stat_d, pend_d;
  logic [SB*8-1:0]  mask_q;

  // a clear hands the slot to the pending event or a same-cycle event
  always_comb begin
    stat_d = (clr_i & (pend_q | evt_i)) | (~clr_i & (stat_q | evt_i));
    pend_d = (clr_i & pend_q & evt_i) | (~clr_i & (pend_q | (stat_q & evt_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pend_q <= '0;
    end else begin
      stat_q <= stat_d;
      pend_q <= pend_d;
    end
  end

  for (genvar gb = 0; gb < SB; gb++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             mask_q[gb*8 +: 8] <= 8'hFF;
      else if (mask_we_i[gb]) mask_q[gb*8 +: 8] <= mask_wdata_i;
    end
  end

  assign stat_o  = stat_q;
  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign irq_n_o = ~|(stat_q & ~mask_q[N_SRC-1:0]);
endmodule

// File: rtl/sih_bank.sv
module sih_bank
  import sih_pkg::*;
#(
  parameter int unsigned N_SRC = 24,
  parameter int unsigned AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [AW-1:0]    reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic             reg_wr,
  input  logic             reg_rd,
  output logic [7:0]       reg_rdata,
  output logic [1:0]       irq_n
);
  localparam int unsigned SB     = (N_SRC + 7) / 8;
  localparam int unsigned EB     = (2 * N_SRC + 7) / 8;
  localparam int unsigned A_MK0  = SB;
  localparam int unsigned A_ST1  = 2 * SB;
  localparam int unsigned A_MK1  = 3 * SB;
  localparam int unsigned A_EDGE = 4 * SB;
  localparam int unsigned A_CTRL = A_EDGE + EB;
  localparam int unsigned A_TSET = A_CTRL + 1;
  localparam int unsigned A_END  = A_TSET + SB;
  localparam int unsigned IW     = $clog2(EB + 1);

  sih_region_e      rg;
  logic [IW-1:0]    idx;
  logic [31:0]      a32;

  logic [EB*8-1:0]  edge_q;
  logic             cor_q;
  logic [SB*8-1:0]  tset_v;
  logic [N_SRC-1:0] det_evt, evt_all;
  logic [SB*8-1:0]  clr_v   [N_LINES];
  logic [SB-1:0]    mwe_v   [N_LINES];
  logic [N_SRC-1:0] st_v    [N_LINES];
  logic [N_SRC-1:0] pd_v    [N_LINES];
  logic [SB*8-1:0]  mask_v  [N_LINES];
  logic [SB*8-1:0]  st_pad  [N_LINES];
  logic [7:0]       rd_byte;

  // address decode into region and byte index
  always_comb begin
    a32 = 32'(reg_addr);
    rg  = RG_NONE;
    idx = '0;
    if (a32 < A_MK0) begin
      rg = RG_STAT0; idx = IW'(a32);
    end else if (a32 < A_ST1) begin
      rg = RG_MASK0; idx = IW'(a32 - A_MK0);
    end else if (a32 < A_MK1) begin
      rg = RG_STAT1; idx = IW'(a32 - A_ST1);
    end else if (a32 < A_EDGE) begin
      rg = RG_MASK1; idx = IW'(a32 - A_MK1);
    end else if (a32 < A_CTRL) begin
      rg = RG_EDGE;  idx = IW'(a32 - A_EDGE);
    end else if (a32 == A_CTRL) begin
      rg = RG_CTRL;
    end else if (a32 < A_END) begin
      rg = RG_TSET;  idx = IW'(a32 - A_TSET);
    end
  end

  // shared configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      cor_q  <= 1'b0;
    end else if (reg_wr) begin
      if (rg == RG_EDGE) edge_q[idx*8 +: 8] <= reg_wdata;
      if (rg == RG_CTRL) cor_q <= reg_wdata[CTRL_COR_BIT];
    end
  end

  always_comb begin
    tset_v = '0;
    if (reg_wr && rg == RG_TSET) tset_v[idx*8 +: 8] = reg_wdata;
  end

  sih_src_detect #(.N_SRC(N_SRC)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .edge_cfg (edge_q[2*N_SRC-1:0]),
    .evt_o    (det_evt)
  );

  assign evt_all = det_evt | tset_v[N_SRC-1:0];

  for (genvar gl = 0; gl < N_LINES; gl++) begin : g_line
    localparam sih_region_e RG_ST = (gl == 0) ? RG_STAT0 : RG_STAT1;
    localparam sih_region_e RG_MK = (gl == 0) ? RG_MASK0 : RG_MASK1;

    always_comb begin
      clr_v[gl] = '0;
      if (rg == RG_ST) begin
        if (cor_q && reg_rd)       clr_v[gl][idx*8 +: 8] = 8'hFF;
        else if (!cor_q && reg_wr) clr_v[gl][idx*8 +: 8] = reg_wdata;
      end
      for (int b = 0; b < SB; b++)
        mwe_v[gl][b] = reg_wr && (rg == RG_MK) && (32'(idx) == b);
    end

    sih_line_bank #(.N_SRC(N_SRC), .SB(SB)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_i        (evt_all),
      .clr_i        (clr_v[gl][N_SRC-1:0]),
      .mask_we_i    (mwe_v[gl]),
      .mask_wdata_i (reg_wdata),
      .stat_o       (st_v[gl]),
      .pend_o       (pd_v[gl]),
      .mask_o       (mask_v[gl]),
      .irq_n_o      (irq_n[gl])
    );

    assign st_pad[gl] = (SB*8)'(st_v[gl]);
  end

  always_comb begin
    unique case (rg)
      RG_STAT0: rd_byte = st_pad[0][idx*8 +: 8];
      RG_MASK0: rd_byte = mask_v[0][idx*8 +: 8];
      RG_STAT1: rd_byte = st_pad[1][idx*8 +: 8];
      RG_MASK1: rd_byte = mask_v[1][idx*8 +: 8];
      RG_EDGE:  rd_byte = edge_q[idx*8 +: 8];
      RG_CTRL:  rd_byte = {7'd0, cor_q};
      default:  rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= 8'h00;
    else if (reg_rd) reg_rdata <= rd_byte;
  end
endmodule

// File: rtl/sih_bank_chk.sv
module sih_bank_chk #(
  parameter int unsigned N_SRC = 24,
  parameter int unsigned SB    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic             cor_q,
  input logic [1:0]       irq_n,
  input logic [N_SRC-1:0] evt_all,
  input logic [N_SRC-1:0] st_v   [2],
  input logic [N_SRC-1:0] pd_v   [2],
  input logic [SB*8-1:0]  mask_v [2]
);
  for (genvar gl = 0; gl < 2; gl++) begin : g_chk
    // R8
    pend_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_v[gl] & ~st_v[gl]) == '0);

    // R12
    pend_holds_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pd_v[gl]) & ~st_v[gl]) == '0);

    // R2
    stat_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_v[gl] & ~$past(st_v[gl]) & ~$past(evt_all)) == '0);

    // R5
    mask_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_v[gl]) |-> irq_n[gl]);

    // R6
    rd_noclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reg_rd) && !$past(reg_wr) && !$past(cor_q))
        |-> (($past(st_v[gl]) & ~st_v[gl]) == '0));
  end
endmodule

bind sih_bank sih_bank_chk #(.N_SRC(N_SRC), .SB(SB)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_rd  (reg_rd),
  .reg_wr  (reg_wr),
  .cor_q   (cor_q),
  .irq_n   (irq_n),
  .evt_all (evt_all),
  .st_v    (st_v),
  .pd_v    (pd_v),
  .mask_v  (mask_v)
);

// File: tb/sih_bank_tb.sv
`timescale 1ns/1ps
module sih_bank_tb;
  localparam int N  = 24;
  localparam int ST0 = 0, MK0 = 3, ST1 = 6, MK1 = 9, EDG = 12, CTL = 18, TST = 19;

  // {source[4:0], edge code[1:0], start level, end level, expected latch}
  localparam logic [9:0] VEC [9] = '{
    {5'd0,  2'b10, 1'b0, 1'b1, 1'b1},
    {5'd0,  2'b10, 1'b1, 1'b0, 1'b0},
    {5'd5,  2'b01, 1'b1, 1'b0, 1'b1},
    {5'd5,  2'b01, 1'b0, 1'b1, 1'b0},
    {5'd9,  2'b11, 1'b0, 1'b1, 1'b1},
    {5'd9,  2'b11, 1'b1, 1'b0, 1'b1},
    {5'd14, 2'b00, 1'b0, 1'b1, 1'b0},
    {5'd23, 2'b10, 1'b0, 1'b1, 1'b1},
    {5'd17, 2'b00, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata, d;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0] irq_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sih_bank #(.N_SRC(N), .AW(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr(addr), .reg_wdata(wdata),
    .reg_wr(wr), .reg_rd(rd), .reg_rdata(rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrb(input int a, input logic [7:0] v);
    @(negedge clk); addr = 5'(a); wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rdb(input int a, output logic [7:0] v);
    @(negedge clk); addr = 5'(a); rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  task automatic clear_all();
    for (int b = 0; b < 3; b++) begin
      wrb(ST0 + b, 8'hFF);
      wrb(ST1 + b, 8'hFF);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq_n", 32'(irq_n), 32'h3);
    rdb(ST0, d);     chk("R1 status", 32'(d), 32'h00);
    rdb(ST1 + 2, d); chk("R1 status1", 32'(d), 32'h00);
    rdb(MK0, d);     chk("R1 mask0", 32'(d), 32'hFF);
    rdb(MK1 + 2, d); chk("R1 mask1", 32'(d), 32'hFF);
    rdb(EDG + 5, d); chk("R1 edge", 32'(d), 32'h00);
    rdb(CTL, d);     chk("R1 ctrl", 32'(d), 32'h00);

    // R11 read data only moves at the sampling edge
    rdb(MK0, d);
    @(negedge clk); addr = ST0; rd = 1'b1;
    #1 chk("R11 hold before edge", 32'(rdata), 32'hFF);
    @(negedge clk); rd = 1'b0;
    chk("R11 after edge", 32'(rdata), 32'h00);
    repeat (2) @(negedge clk);
    chk("R11 hold without strobe", 32'(rdata), 32'h00);

    // R2 R3 R4 R10 edge table
    foreach (VEC[k]) begin
      int s;
      s = int'(VEC[k][9:5]);
      wrb(EDG + s / 4, 8'(VEC[k][4:3]) << ((s % 4) * 2));
      @(negedge clk); src[s] = VEC[k][2];
      repeat (4) @(negedge clk);
      clear_all();
      @(negedge clk); src[s] = VEC[k][1];
      repeat (4) @(negedge clk);
      rdb(ST0 + s / 8, d);
      chk($sformatf("R2/R3/R4/R10 line0 vec%0d", k), 32'(d), 32'(8'(VEC[k][0]) << (s % 8)));
      rdb(ST1 + s / 8, d);
      chk($sformatf("R2/R3/R4/R10 line1 vec%0d", k), 32'(d), 32'(8'(VEC[k][0]) << (s % 8)));
      chk("R5 fully masked", 32'(irq_n), 32'h3);
    end
    clear_all();

    // R9 R5 test set and masking
    wrb(TST, 8'h08);
    chk("R5 masked high", 32'(irq_n), 32'h3);
    rdb(ST1, d); chk("R9 set both lines", 32'(d), 32'h08);
    wrb(MK0, 8'hF7);
    chk("R5 line0 unmasked", 32'(irq_n), 32'h2);
    wrb(MK1, 8'hEF);
    chk("R5 other bit unmasked", 32'(irq_n), 32'h2);
    wrb(MK1, 8'hF7);
    chk("R5 both unmasked", 32'(irq_n), 32'h0);

    // R6 write-one-to-clear
    rdb(ST0, d); chk("R6 read", 32'(d), 32'h08);
    rdb(ST0, d); chk("R6 read keeps", 32'(d), 32'h08);
    wrb(ST0, 8'h00);
    rdb(ST0, d); chk("R6 zero write keeps", 32'(d), 32'h08);
    wrb(ST0, 8'h08);
    rdb(ST0, d); chk("R6 one write clears", 32'(d), 32'h00);
    chk("R5 lines independent", 32'(irq_n), 32'h1);

    // R7 clear-on-read
    wrb(CTL, 8'h01);
    wrb(ST1, 8'hFF);
    rdb(ST1, d); chk("R7 write ignored", 32'(d), 32'h08);
    rdb(ST1, d); chk("R7 read cleared", 32'(d), 32'h00);
    chk("R7 irq released", 32'(irq_n), 32'h3);
    wrb(CTL, 8'h00);

    // R8 one pending event
    wrb(TST + 1, 8'h01); wrb(TST + 1, 8'h01);
    rdb(ST0 + 1, d); chk("R8 set", 32'(d), 32'h01);
    wrb(ST0 + 1, 8'h01);
    rdb(ST0 + 1, d); chk("R8 reasserted", 32'(d), 32'h01);
    wrb(ST0 + 1, 8'h01);
    rdb(ST0 + 1, d); chk("R8 drained", 32'(d), 32'h00);
    wrb(TST + 1, 8'h01); wrb(TST + 1, 8'h01); wrb(TST + 1, 8'h01);
    wrb(ST0 + 1, 8'h01);
    rdb(ST0 + 1, d); chk("R8 one pending only", 32'(d), 32'h01);
    wrb(ST0 + 1, 8'h01);
    rdb(ST0 + 1, d); chk("R8 no stacking", 32'(d), 32'h00);
    clear_all(); clear_all();

    // R12 event coincident with clear (source 8 rising, edge byte 2 bit 1)
    wrb(EDG + 2, 8'h02);
    wrb(TST + 1, 8'h01);
    @(negedge clk); src[8] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 5'(ST0 + 1); wdata = 8'h01; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rdb(ST0 + 1, d); chk("R12 event kept", 32'(d), 32'h01);
    wrb(ST0 + 1, 8'h01);
    rdb(ST0 + 1, d); chk("R12 then clears", 32'(d), 32'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule